// File: doc/BRIEF.md
# Addressed Single-Bit Discrete I/O Bank

This block holds a bank of sixteen one-bit output latches. Each latch drives its own bidirectional pad through an open-drain or pull-up structure outside the block. A latch can be set or cleared one at a time. The address comes either from a 4-bit index register held elsewhere, which reaches all sixteen bits, or from a 2-bit instruction operand, which reaches only bits 0 to 3. A test operation returns the level seen at the addressed pad.

The latch keeps driving its pad while a test runs, so the value read back is the latch wired-ANDed with whatever the outside world drives. Software must set a latch to 1 before it can sense an external level on that pad. All latches come out of reset at 1 so that the pads start released. A set and a clear issued in the same cycle are refused. When that happens, no latch changes and an error flag is raised for one cycle.

Top module: `dio_bank`

## Requirements
- R1: While rst_ni is low, latch_o is all ones, err_o is 0 and test_o is 0.
- R2: With direct_i=0 the target bit is the value of idx_i. With direct_i=1 the target bit is opnd_i (bits 0 to 3), and idx_i has no effect.
- R3: A cycle with set_i=1 and clr_i=0 makes the target latch 1 from the next rising edge.
- R4: A cycle with clr_i=1 and set_i=0 makes the target latch 0 from the next rising edge.
- R5: A write changes no latch other than the target one. A cycle with neither strobe changes no latch.
- R6: A cycle with set_i=1 and clr_i=1 changes no latch.
- R7: err_o is 1 for exactly the one cycle that follows a cycle with both set_i and clr_i high, and is 0 otherwise.
- R8: While test_i=1, test_o equals latch_o[target] AND pin_i[target] in the same cycle, with no register in the path. While test_i=0, test_o is 0.
- R9: A test in the same cycle as a write to the same bit returns the latch value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 1 | Set strobe for the target latch |
| clr_i | input | 1 | Clear strobe for the target latch |
| test_i | input | 1 | Test strobe for the target pad |
| direct_i | input | 1 | 1 selects operand addressing, 0 selects index addressing |
| idx_i | input | 4 | Index register value |
| opnd_i | input | 2 | Direct operand, bits 0 to 3 |
| pin_i | input | 16 | Levels sensed at the pads |
| latch_o | output | 16 | Latch values driving the pads |
| test_o | output | 1 | Test result |
| err_o | output | 1 | Set and clear conflict flag |

## Verification
test_o is combinational, so the bench checks it one nanosecond after it drives the inputs on the falling edge, before the next rising edge. Latch writes and err_o are registered, so the bench checks them one nanosecond after the rising edge that follows the strobe, against a reference vector it updates at that same edge. The bench sweeps every index through set, clear and test, runs each direct operand while idx_i points elsewhere, and places a test in the same cycle as a write to show that the pre-edge value is returned.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic [1:0] {
    WR_NONE     = 2'd0,
    WR_SET      = 2'd1,
    WR_CLR      = 2'd2,
    WR_CONFLICT = 2'd3
  } wr_op_e;

  function automatic wr_op_e decode_wr(input logic set, input logic clr);
    case ({clr, set})
      2'b01:   return WR_SET;
      2'b10:   return WR_CLR;
      2'b11:   return WR_CONFLICT;
      default: return WR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dio_addr_sel.sv
module dio_addr_sel #(
  parameter int N_BITS   = 16,
  parameter int DIRECT_N = 4,
  localparam int AW = $clog2(N_BITS),
  localparam int DW = (DIRECT_N > 1) ? $clog2(DIRECT_N) : 1
) (
  input  logic          direct_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] opnd_i,
  output logic [AW-1:0] addr_o,
  output logic [N_BITS-1:0] sel_o
);
  assign addr_o = direct_i ? {{(AW-DW){1'b0}}, opnd_i} : idx_i;

  for (genvar i = 0; i < N_BITS; i++) begin : g_sel
    assign sel_o[i] = (addr_o == AW'(i));
  end
endmodule

// File: rtl/dio_latch_bank.sv
module dio_latch_bank
  import dio_pkg::*;
#(
  parameter int N_BITS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] sel_i,
  input  wr_op_e            wr_i,
  output logic [N_BITS-1:0] latch_o
);
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         latch_o[i] <= 1'b1;
      else if (sel_i[i] && wr_i == WR_SET) latch_o[i] <= 1'b1;
      else if (sel_i[i] && wr_i == WR_CLR) latch_o[i] <= 1'b0;
    end
  end

  a_r3_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i == WR_SET |=> ((latch_o & $past(sel_i)) == $past(sel_i)));

  a_r4_clr_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i == WR_CLR |=> ((latch_o & $past(sel_i)) == '0));

  a_r5_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((latch_o ^ $past(latch_o)) & ~$past(sel_i)) == '0));

  a_r6_conflict_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i == WR_CONFLICT |=> $stable(latch_o));
endmodule

// File: rtl/dio_test_mux.sv
module dio_test_mux #(
  parameter int N_BITS = 16,
  localparam int AW = $clog2(N_BITS)
) (
  input  logic              test_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [N_BITS-1:0] latch_i,
  input  logic [N_BITS-1:0] pin_i,
  output logic              test_o
);
  // pad level is latch wired-AND external drive
  logic [N_BITS-1:0] pad_lvl;
  assign pad_lvl = latch_i & pin_i;
  assign test_o  = test_i & pad_lvl[addr_i];
endmodule

// File: rtl/dio_bank.sv
module dio_bank
  import dio_pkg::*;
#(
  parameter int N_BITS   = 16,
  parameter int DIRECT_N = 4,
  localparam int AW = $clog2(N_BITS),
  localparam int DW = (DIRECT_N > 1) ? $clog2(DIRECT_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              test_i,
  input  logic              direct_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [DW-1:0]     opnd_i,
  input  logic [N_BITS-1:0] pin_i,
  output logic [N_BITS-1:0] latch_o,
  output logic              test_o,
  output logic              err_o
);
  logic [AW-1:0]     addr;
  logic [N_BITS-1:0] sel;
  wr_op_e            wr;

  assign wr = decode_wr(set_i, clr_i);

  dio_addr_sel #(.N_BITS(N_BITS), .DIRECT_N(DIRECT_N)) u_addr (
    .direct_i(direct_i),
    .idx_i   (idx_i),
    .opnd_i  (opnd_i),
    .addr_o  (addr),
    .sel_o   (sel)
  );

  dio_latch_bank #(.N_BITS(N_BITS)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .wr_i   (wr),
    .latch_o(latch_o)
  );

  dio_test_mux #(.N_BITS(N_BITS)) u_test (
    .test_i (test_i),
    .addr_i (addr),
    .latch_i(latch_o),
    .pin_i  (pin_i),
    .test_o (test_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= (wr == WR_CONFLICT);
  end

  a_r7_err_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> err_o);

  a_r7_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i) |=> !err_o);

  a_r8_test_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |-> !test_o);

  a_r2_direct_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_i |-> ($countones(sel) == 1 && sel[N_BITS-1:DIRECT_N] == '0));
endmodule

// File: tb/dio_bank_tb.sv
`timescale 1ns/1ps
module dio_bank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        set_i = 0, clr_i = 0, test_i = 0, direct_i = 0;
  logic [3:0]  idx_i = '0;
  logic [1:0]  opnd_i = '0;
  logic [15:0] pin_i = '1;
  logic [15:0] latch_o;
  logic        test_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] model;

  always #2 clk_i = ~clk_i;

  dio_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .clr_i(clr_i),
    .test_i(test_i), .direct_i(direct_i), .idx_i(idx_i), .opnd_i(opnd_i),
    .pin_i(pin_i), .latch_o(latch_o), .test_o(test_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one operation: drive at negedge, test_o checked same cycle, latches after edge
  task automatic step(input logic s, input logic c, input logic t, input logic d,
                      input logic [3:0] y, input logic [1:0] o, input logic [15:0] p);
    logic [3:0] a;
    string lbl;
    @(negedge clk_i);
    set_i = s; clr_i = c; test_i = t; direct_i = d; idx_i = y; opnd_i = o; pin_i = p;
    a = d ? {2'b00, o} : y;
    #1;
    if (t) check((s || c) ? "R9" : (d ? "R2" : "R8"), 32'(test_o), 32'(model[a] & p[a]));
    else   check("R8", 32'(test_o), 32'd0);
    @(posedge clk_i);
    if (s && !c)      model[a] = 1'b1;
    else if (c && !s) model[a] = 1'b0;
    #1;
    if (s && c)      lbl = "R6";
    else if (d)      lbl = "R2";
    else if (s)      lbl = "R3";
    else if (c)      lbl = "R4";
    else             lbl = "R5";
    check(lbl, 32'(latch_o), 32'(model));
    check("R7", 32'(err_o), 32'(s && c));
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model = '1;
    #5;
    check("R1", 32'(latch_o), 32'hFFFF);
    check("R1", 32'(err_o), 32'd0);
    check("R1", 32'(test_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // index sweep over all bits
    for (int i = 0; i < 16; i++) begin
      step(0, 1, 0, 0, 4'(i), 2'd0, 16'hFFFF);            // clear
      step(0, 0, 1, 0, 4'(i), 2'd0, 16'hFFFF);            // test: latch 0 dominates
      step(1, 0, 1, 0, 4'(i), 2'd0, 16'hFFFF);            // set with same-cycle test
      step(0, 0, 1, 0, 4'(i), 2'd0, ~(16'h1 << i));       // pin low at target
      step(0, 0, 1, 0, 4'(i), 2'd0, 16'h1 << i);          // only target pin high
      step(0, 0, 0, 0, 4'(i), 2'd0, 16'hFFFF);            // idle, test off
    end

    // direct operand with index pointing elsewhere
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 0, 1, 4'(15 - k), 2'(k), 16'hFFFF);
      step(0, 0, 1, 1, 4'(15 - k), 2'(k), 16'hFFFF);
      step(0, 0, 1, 0, 4'(15 - k), 2'(k), 16'hFFFF);      // index target still 1
      step(1, 0, 1, 1, 4'(15 - k), 2'(k), 16'hFFFF);
      step(0, 0, 1, 1, 4'(15 - k), 2'(k), 16'h5555 << k);
    end

    // several bits cleared at once, then conflicts
    step(0, 1, 0, 0, 4'd5, 2'd0, 16'hFFFF);
    step(0, 1, 0, 1, 4'd9, 2'd2, 16'hFFFF);
    step(1, 1, 1, 0, 4'd5, 2'd0, 16'hFFFF);               // conflict keeps 0
    step(1, 1, 0, 0, 4'd7, 2'd0, 16'hFFFF);               // back-to-back conflict
    step(0, 0, 1, 0, 4'd5, 2'd0, 16'hFFFF);               // err drops
    step(1, 1, 0, 1, 4'd0, 2'd2, 16'hFFFF);
    step(1, 0, 0, 1, 4'd0, 2'd2, 16'hFFFF);
    step(1, 0, 0, 0, 4'd5, 2'd0, 16'hFFFF);
    step(0, 0, 0, 0, 4'd0, 2'd0, 16'h0000);

    @(negedge clk_i);
    set_i = 0; clr_i = 0; test_i = 0;
    check("R1", 32'(latch_o), 32'hFFFF);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule